// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one channel of a timer that makes a pulse-width-modulated output. It compares a time base against two compare values, a leading-edge value and a trailing-edge value. A match on the leading value drives the pin to the polarity level. A match on the trailing value drives it back to the inactive level. Each compare value sits behind a shadow register, so software can stage a new pair of values while the current period runs. The new values take effect together at a safe instant, and no glitch appears on the pin.

Three modes are provided:

- **Edge-placed:** both edges are compared against an external counter bus that many channels share.
- **Frequency:** a private counter restarts on the trailing match, so the trailing value sets the period.
- **Trigger:** for lighting-style use, a third compare point on the shared bus raises an event flag, for example to start an ADC conversion. In this mode the trailing value is reloaded at each leading-edge match.

Top module: `dbuf_pwm_chan`

## Requirements
- R1: While reset is held, pin_out, flag_out and evt_out are 0, and lead_rd and trail_rd read 0.
- R2: On a clock edge with no configuration change, a trailing-value match drives pin_out to the inverse of pol from the next cycle. Otherwise a leading-value match drives pin_out to pol. When both values match at once, the trailing match wins. With no match, the pin holds its level.
- R3: A write with wr_sel=0 stages a new leading value and wr_sel=1 stages a new trailing value. lead_rd and trail_rd always return the active values. In mode 0, 1 or 3, staged values move to the active registers at the clock edge of the next trailing-value match.
- R4: In mode 1 (frequency), the compare source is an internal counter that goes to 0 after a trailing match and otherwise increments. The pin is at the inactive level for leading+1 cycles and at pol for trailing-leading cycles, so the period is trailing+1 cycles.
- R5: In mode 0 (and mode 3, which behaves the same), both values are compared against ext_cnt.
- R6: In mode 2 (trigger), a wr_sel=0 write updates the active leading value at once, and a wr_sel=2 write sets the trigger compare value. An ext_cnt match on the trigger value raises the event. A staged trailing value moves to the active register at a leading-value match.
- R7: In modes 0, 1 and 3, a trailing match raises the event. A leading match also raises it when flag_both=1.
- R8: An event pulses evt_out high for exactly one cycle and sets flag_out. flag_out stays set until a cycle with flag_clr=1 and no new event clears it. A new event wins over a clear.
- R9: The internal counter wraps from all-ones to 0. Entering mode 1 with the counter above the trailing value therefore wraps before the first match.
- R10: In the first cycle after reset, or after any change of mode or pol, pin_out goes to the inverse of pol regardless of matches.
- R11: In modes 0, 1 and 3, a wr_sel=2 write has no effect, and wr_sel=3 is ignored in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_cnt | input | CNT_W | Shared counter bus value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 leading, 1 trailing, 2 trigger point, 3 none |
| wr_data | input | CNT_W | Write data |
| mode | input | 2 | 0 edge-placed, 1 frequency, 2 trigger, 3 as 0 |
| pol | input | 1 | Level driven on a leading match |
| flag_both | input | 1 | Events on leading matches as well (modes 0, 1, 3) |
| flag_clr | input | 1 | Clear the sticky flag |
| pin_out | output | 1 | PWM output |
| flag_out | output | 1 | Sticky event flag |
| evt_out | output | 1 | One-cycle event pulse |
| lead_rd | output | CNT_W | Active leading value |
| trail_rd | output | CNT_W | Active trailing value |

## Verification
The bench builds the channel with an 8-bit counter (CNT_W=8). This brings the internal counter's wrap within a few hundred cycles, so entry into frequency mode from above the trailing value, and the wrap delay itself, can be timed exactly. The narrow width also means random ext_cnt values hit the compare points often. Simultaneous leading and trailing matches, writes landing on transfer edges, and mode changes in mid-period therefore all occur during the random phase.

// File: rtl/pwm_chan_pkg.sv
// Shared encodings for the PWM timer channel.
package pwm_chan_pkg;
    typedef enum logic [1:0] {
        PM_EDGE = 2'd0,
        PM_FREQ = 2'd1,
        PM_TRIG = 2'd2,
        PM_ALT  = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        WS_LEAD  = 2'd0,
        WS_TRAIL = 2'd1,
        WS_TRIG  = 2'd2,
        WS_NONE  = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/pwm_shadow_stage.sv
// Two-stage compare register: a shadow stage written by software and an
// active stage used by the comparator. Assumes the caller decides which of
// the write strobes applies in the current mode; at most one is used per write.
module pwm_shadow_stage #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_shd,   // write shadow and mark it pending
    input  logic         ld_shd,   // write shadow without pending mark
    input  logic         wr_act,   // write active stage directly
    input  logic [W-1:0] wdata,
    input  logic         xfer,     // transfer instant
    output logic [W-1:0] act,
    output logic [W-1:0] shd
);
    logic pend;

    // Update active/shadow stages and the pending mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            shd  <= '0;
            pend <= 1'b0;
        end else begin
            if (wr_act)
                act <= wdata;
            else if (xfer && pend)
                act <= shd;
            if (wr_shd || ld_shd)
                shd <= wdata;
            if (wr_shd)
                pend <= 1'b1;
            else if (xfer)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
// Internal free-running counter. It wraps naturally at all-ones and goes
// to zero when the clear input is high.
module pwm_timebase #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Count up, or restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pwm_out_ctl.sv
// Output flip-flop, event pulse and sticky flag. Assumes the match inputs
// come from the same compare source and that chg marks a config change.
module pwm_out_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic a_hit,
    input  logic b_hit,
    input  logic t_hit,
    input  logic trig,
    input  logic flag_both,
    input  logic pol,
    input  logic chg,
    input  logic flag_clr,
    output logic pin,
    output logic flag,
    output logic evt
);
    logic evt_c;

    // Select the event source for the mode.
    always_comb begin
        if (trig)
            evt_c = t_hit;
        else
            evt_c = b_hit | (flag_both & a_hit);
    end

    // Drive the pin level: config change, then trailing, then leading match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin <= 1'b0;
        else if (chg || b_hit)
            pin <= ~pol;
        else if (a_hit)
            pin <= pol;
    end

    // Register the event pulse and the sticky flag (set beats clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt  <= 1'b0;
            flag <= 1'b0;
        end else begin
            evt <= evt_c;
            if (evt_c)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dbuf_pwm_chan.sv
// Top of the double-buffered PWM channel. It selects the compare source,
// forms the matches and routes writes to the shadow stages per mode.
// Assumes ext_cnt is synchronous to clk.
module dbuf_pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ext_cnt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       mode,
    input  logic             pol,
    input  logic             flag_both,
    input  logic             flag_clr,
    output logic             pin_out,
    output logic             flag_out,
    output logic             evt_out,
    output logic [CNT_W-1:0] lead_rd,
    output logic [CNT_W-1:0] trail_rd
);
    localparam int CFG_W = 3;

    pwm_mode_e        cur_mode;
    wr_sel_e          sel;
    logic             is_freq, is_trig;
    logic [CNT_W-1:0] int_cnt, cmp;
    logic [CNT_W-1:0] lead_act, lead_shd, trail_act, trail_shd;
    logic             a_hit, b_hit, t_hit, chg;
    logic             lead_wr_shd, lead_wr_act, lead_ld_shd, lead_xfer;
    logic             trail_wr_shd, trail_xfer;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_vld;

    assign cur_mode = pwm_mode_e'(mode);
    assign sel      = wr_sel_e'(wr_sel);
    assign is_freq  = (cur_mode == PM_FREQ);
    assign is_trig  = (cur_mode == PM_TRIG);

    // Compare source and match detection.
    always_comb begin
        cmp   = is_freq ? int_cnt : ext_cnt;
        a_hit = (cmp == lead_act);
        b_hit = (cmp == trail_act);
        t_hit = is_trig && (cmp == lead_shd);
    end

    // Track the last applied mode/polarity to spot configuration changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            cfg_vld <= 1'b0;
        end else begin
            cfg_q   <= {mode, pol};
            cfg_vld <= 1'b1;
        end
    end
    assign chg = !cfg_vld || (cfg_q != {mode, pol});

    // Route writes and transfer instants per mode.
    always_comb begin
        lead_wr_shd  = wr_en && (sel == WS_LEAD) && !is_trig;
        lead_wr_act  = wr_en && (sel == WS_LEAD) && is_trig;
        lead_ld_shd  = wr_en && (sel == WS_TRIG) && is_trig;
        lead_xfer    = !is_trig && b_hit;
        trail_wr_shd = wr_en && (sel == WS_TRAIL);
        trail_xfer   = is_trig ? a_hit : b_hit;
    end

    pwm_shadow_stage #(.W(CNT_W)) u_lead (
        .clk(clk), .rst_n(rst_n),
        .wr_shd(lead_wr_shd), .ld_shd(lead_ld_shd), .wr_act(lead_wr_act),
        .wdata(wr_data), .xfer(lead_xfer),
        .act(lead_act), .shd(lead_shd)
    );

    pwm_shadow_stage #(.W(CNT_W)) u_trail (
        .clk(clk), .rst_n(rst_n),
        .wr_shd(trail_wr_shd), .ld_shd(1'b0), .wr_act(1'b0),
        .wdata(wr_data), .xfer(trail_xfer),
        .act(trail_act), .shd(trail_shd)
    );

    pwm_timebase #(.W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .clr(is_freq && b_hit),
        .cnt(int_cnt)
    );

    pwm_out_ctl u_out (
        .clk(clk), .rst_n(rst_n),
        .a_hit(a_hit), .b_hit(b_hit), .t_hit(t_hit),
        .trig(is_trig), .flag_both(flag_both), .pol(pol), .chg(chg),
        .flag_clr(flag_clr),
        .pin(pin_out), .flag(flag_out), .evt(evt_out)
    );

    assign lead_rd  = lead_act;
    assign trail_rd = trail_act;
endmodule

// File: rtl/pwm_chan_chk.sv
// Checker for the PWM channel, attached by bind. Observes match, config
// and register signals and relates them to the pin, flag and counter.
module pwm_chan_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pol,
    input logic         is_freq,
    input logic         is_trig,
    input logic         chg,
    input logic         a_hit,
    input logic         b_hit,
    input logic [W-1:0] cnt,
    input logic         pin,
    input logic         flag,
    input logic         evt,
    input logic [W-1:0] a1,
    input logic [W-1:0] b1,
    input logic         a_wr_act,
    input logic         a_xfer
);
    // R2
    trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && b_hit) |=> (pin == !$past(pol)));

    // R2
    lead_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && a_hit && !b_hit) |=> (pin == $past(pol)));

    // R10
    cfg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (pin == !$past(pol)));

    // R8
    evt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> flag);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_freq && b_hit) |=> (cnt == '0));

    // R3
    lead_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a1) |-> $past(a_xfer || a_wr_act));

    // R6
    trail_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(b1) && $past(is_trig)) |-> $past(a_hit));
endmodule

bind dbuf_pwm_chan pwm_chan_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pol(pol), .is_freq(is_freq), .is_trig(is_trig),
    .chg(chg), .a_hit(a_hit), .b_hit(b_hit), .cnt(int_cnt), .pin(pin_out),
    .flag(flag_out), .evt(evt_out), .a1(lead_act), .b1(trail_act),
    .a_wr_act(lead_wr_act), .a_xfer(lead_xfer)
);

// File: tb/dbuf_pwm_chan_tb.sv
`timescale 1ns/1ps
module dbuf_pwm_chan_tb;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] ext_cnt = 8'd200;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [BW-1:0] wr_data = '0;
    logic [1:0]    mode = 2'd0;
    logic          pol = 1'b0;
    logic          flag_both = 1'b0;
    logic          flag_clr = 1'b0;
    logic          pin_out, flag_out, evt_out;
    logic [BW-1:0] lead_rd, trail_rd;

    int n_chk = 0;
    int n_err = 0;
    bit model_on = 1'b0;

    // Bench reference state.
    logic [BW-1:0] m_a1, m_a2, m_b1, m_b2, m_cnt;
    logic          m_ap, m_bp, m_pin, m_flag, m_evt, m_vld;
    logic [2:0]    m_cfg;

    always #4 clk = ~clk;

    dbuf_pwm_chan #(.CNT_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_cnt(ext_cnt), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .mode(mode), .pol(pol),
        .flag_both(flag_both), .flag_clr(flag_clr), .pin_out(pin_out),
        .flag_out(flag_out), .evt_out(evt_out), .lead_rd(lead_rd),
        .trail_rd(trail_rd)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Reference model, stepped on each rising edge from the requirements.
    always @(posedge clk) begin
        logic isf, ist, ah, bh, th, ch, ev, xb;
        logic [BW-1:0] cmpv, na1, na2, nb1, nb2;
        logic nap, nbp;
        if (!rst_n) begin
            m_a1 = '0; m_a2 = '0; m_b1 = '0; m_b2 = '0; m_cnt = '0;
            m_ap = 0; m_bp = 0; m_pin = 0; m_flag = 0; m_evt = 0;
            m_vld = 0; m_cfg = '0;
        end else begin
            isf  = (mode == 2'd1);
            ist  = (mode == 2'd2);
            cmpv = isf ? m_cnt : ext_cnt;
            ah = (cmpv == m_a1);
            bh = (cmpv == m_b1);
            th = ist && (cmpv == m_a2);
            ch = !m_vld || (m_cfg != {mode, pol});
            ev = ist ? th : (bh | (flag_both & ah));
            na1 = m_a1; na2 = m_a2; nap = m_ap;
            nb1 = m_b1; nb2 = m_b2; nbp = m_bp;
            if (wr_en && wr_sel == 2'd0 && ist) na1 = wr_data;
            else if (!ist && bh && m_ap) na1 = m_a2;
            if (wr_en && ((wr_sel == 2'd0 && !ist) || (wr_sel == 2'd2 && ist))) na2 = wr_data;
            if (wr_en && wr_sel == 2'd0 && !ist) nap = 1;
            else if (!ist && bh) nap = 0;
            xb = ist ? ah : bh;
            if (xb && m_bp) nb1 = m_b2;
            if (wr_en && wr_sel == 2'd1) begin nb2 = wr_data; nbp = 1; end
            else if (xb) nbp = 0;
            if (ch || bh) m_pin = ~pol;
            else if (ah) m_pin = pol;
            if (ev) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            m_evt = ev;
            m_cnt = (isf && bh) ? '0 : m_cnt + 1'b1;
            m_a1 = na1; m_a2 = na2; m_ap = nap;
            m_b1 = nb1; m_b2 = nb2; m_bp = nbp;
            m_cfg = {mode, pol};
            m_vld = 1;
        end
    end

    // Per-cycle comparison against the reference, away from the edge.
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(int'(pin_out),  int'(m_pin),  "R2 pin level");
            check(int'(evt_out),  int'(m_evt),  "R8 event pulse");
            check(int'(flag_out), int'(m_flag), "R8 sticky flag");
            check(int'(lead_rd),  int'(m_a1),   "R3 leading read");
            check(int'(trail_rd), int'(m_b1),   "R3 trailing read");
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [BW-1:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_sel = 2'd3;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hi, lo, cnt, hit_at, n;
        logic [BW-1:0] c0;

        // R1: reset state.
        cyc(3);
        check(int'(pin_out), 0, "R1 pin in reset");
        check(int'(flag_out), 0, "R1 flag in reset");
        check(int'(evt_out), 0, "R1 evt in reset");
        check(int'(lead_rd), 0, "R1 lead in reset");
        check(int'(trail_rd), 0, "R1 trail in reset");
        rst_n = 1; model_on = 1;
        @(negedge clk);
        check(int'(pin_out), 1, "R10 first cycle after reset");

        // Frequency mode, pol=1.
        mode = 2'd1; pol = 1;
        @(negedge clk);
        check(int'(pin_out), 0, "R10 mode change");
        wr(2'd0, 8'd3);
        check(int'(lead_rd), 0, "R3 write goes to shadow");
        wr(2'd1, 8'd9);
        n = 0;
        while (!(lead_rd == 8'd3 && trail_rd == 8'd9) && n < 600) begin @(negedge clk); n++; end
        check(int'(trail_rd), 9, "R3 transfer at period boundary");
        n = 0;
        while (!(pin_out == 0) && n < 50) begin @(negedge clk); n++; end
        n = 0;
        while (!(pin_out == 1) && n < 50) begin @(negedge clk); n++; end
        hi = 0; while (pin_out == 1 && hi < 50) begin @(negedge clk); hi++; end
        lo = 0; while (pin_out == 0 && lo < 50) begin @(negedge clk); lo++; end
        check(hi, 6, "R4 active length");
        check(lo, 4, "R4 inactive length");

        // R7: event select.
        cnt = 0; for (int i = 0; i < 10; i++) begin @(negedge clk); if (evt_out) cnt++; end
        check(cnt, 1, "R7 trailing-only events");
        flag_both = 1;
        cnt = 0; for (int i = 0; i < 10; i++) begin @(negedge clk); if (evt_out) cnt++; end
        check(cnt, 2, "R7 both-match events");
        flag_both = 0;

        // R8: sticky flag and clear.
        @(negedge clk);
        n = 0; while (!evt_out && n < 30) begin @(negedge clk); n++; end
        @(negedge clk);
        check(int'(flag_out), 1, "R8 flag sticky");
        flag_clr = 1; @(negedge clk); flag_clr = 0;
        check(int'(flag_out), 0, "R8 flag cleared");

        // R9: wrap on entry above trailing value.
        mode = 2'd0; ext_cnt = 8'd200;
        cyc(50);
        c0 = m_cnt;
        mode = 2'd1;
        n = 0;
        do begin @(negedge clk); n++; end while (!evt_out && n < 400);
        check(n, int'(8'(8'd9 - c0)) + 1, "R9 wrap before first match");

        // R5: edge-placed mode on ext_cnt, pol=0.
        mode = 2'd0; pol = 0;
        @(negedge clk);
        check(int'(pin_out), 1, "R10 polarity change");
        wr(2'd0, 8'd40);
        wr(2'd1, 8'd80);
        ext_cnt = 8'd9; @(negedge clk); ext_cnt = 8'd200;
        check(int'(lead_rd), 40, "R3 lead after boundary");
        check(int'(trail_rd), 80, "R3 trail after boundary");
        ext_cnt = 8'd40; @(negedge clk);
        check(int'(pin_out), 0, "R5 leading edge on bus");
        ext_cnt = 8'd60; @(negedge clk);
        check(int'(pin_out), 0, "R5 level held");
        ext_cnt = 8'd80; @(negedge clk);
        check(int'(pin_out), 1, "R5 trailing edge on bus");
        ext_cnt = 8'd200;

        // R6: trigger mode.
        mode = 2'd2; pol = 1;
        @(negedge clk);
        wr(2'd0, 8'd10);
        check(int'(lead_rd), 10, "R6 leading written directly");
        wr(2'd2, 8'd30);
        wr(2'd1, 8'd50);
        check(int'(trail_rd), 80, "R6 trailing staged");
        cnt = 0; hit_at = -1;
        for (int i = 0; i < 100; i++) begin
            ext_cnt = 8'(i);
            @(negedge clk);
            if (evt_out) begin cnt++; hit_at = i; end
        end
        check(cnt, 1, "R6 one trigger event");
        check(hit_at, 30, "R6 trigger point");
        check(int'(trail_rd), 50, "R6 trailing reload at leading match");
        ext_cnt = 8'd200;

        // R11: trigger-point write ignored outside trigger mode.
        mode = 2'd0; @(negedge clk);
        wr(2'd2, 8'd77);
        wr(2'd3, 8'd66);
        ext_cnt = 8'd50; @(negedge clk); ext_cnt = 8'd200;
        check(int'(lead_rd), 10, "R11 trigger write ignored");
        check(int'(trail_rd), 50, "R11 none-select ignored");

        // Random phase against the reference.
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 200) == 0) mode = 2'($urandom);
            if (($urandom % 300) == 0) pol = ~pol;
            if (($urandom % 100) == 0) flag_both = ~flag_both;
            flag_clr = (($urandom % 8) == 0);
            wr_en = (($urandom % 6) == 0);
            wr_sel = 2'($urandom);
            wr_data = 8'($urandom);
            if (($urandom % 16) == 0) ext_cnt = 8'($urandom);
            else ext_cnt = ext_cnt + 1'b1;
            @(negedge clk);
        end
        wr_en = 0; flag_clr = 0;
        cyc(2);
        finish_run();
    end
endmodule